// File: doc/BRIEF.md
# Two-Adapter Interrupt Level Arbiter with Vector Lookup

This block gathers 32 device interrupt request lines that belong to two bus adapters. Each adapter sorts its lines into a high-priority group and a low-priority group. Software sets a processor interrupt level (1 to 7, with 0 meaning unassigned) for each group through per-group level inputs. The block folds all pending requests into a 7-bit level bitmap for the processor's interrupt unit.

When the processor acknowledges a level, the block looks for a matching group. It checks adapter 0 before adapter 1, and within each adapter it checks the high group before the low group. In the chosen group, the lowest-numbered pending line wins. The block clears that line's pending bit and, one cycle later, returns the line's vector from a 32-entry table together with an encoded adapter number. The vector table is loaded through a simple write port.

Line-to-group assignment is fixed by parameters. With the defaults, lines 0-3 form adapter 0's high group and lines 4-7 its low group. Lines 8-15 form adapter 1's high group and lines 16-31 its low group.

Top module: `irq_vector_arbiter`

## Requirements
- R1: A 1 on bit i of `reqSet` at a clock edge makes line i pending. The line stays pending until an acknowledge selects it. If a line is set and selected at the same edge, it stays pending.
- R2: While any line in an adapter's high group is pending and that adapter's high level field L is nonzero, `levelReq[L-1]` is 1. The high level field of adapter a is `hiLevels[3a+2:3a]`.
- R3: While any line in an adapter's low group is pending and that adapter's low level field L is nonzero, `levelReq[L-1]` is 1. The low level field of adapter a is `loLevels[3a+2:3a]`.
- R4: `levelReq` is the OR of the contributions from all four groups. A group whose level field is 0 contributes nothing, and a `levelReq` bit with no contributing group is 0.
- R5: On `ackValid` with level L, the groups are searched in this order: adapter 0 high, adapter 0 low, adapter 1 high, adapter 1 low. The first group whose nonzero level field equals L and that has a pending line is chosen.
- R6: Within the chosen group, the lowest-numbered pending line wins, and its pending bit is cleared at the acknowledge edge.
- R7: `rspValid` is 1 in exactly the cycle after each cycle with `ackValid` high. When a line won, `rspVector` is that line's vector-table entry as it was before that edge.
- R8: When no group matches the acknowledged level, `rspVector` and `rspAdapter` are 0 and no pending line is cleared.
- R9: On a hit, `rspAdapter` is twice the winning adapter index plus one: 1 for adapter 0 and 3 for adapter 1.
- R10: A cycle with `vecWrEn` high writes `vecWrData` into entry `vecWrAddr` at the clock edge. An acknowledge in the same cycle reads the old entry.
- R11: While `rstN` is low, all pending lines, all vector entries and `rspValid` are cleared, and `levelReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqSet | input | 32 | Per-line request set pulses |
| hiLevels | input | 6 | Processor level for each adapter's high group, 3 bits per adapter |
| loLevels | input | 6 | Processor level for each adapter's low group, 3 bits per adapter |
| levelReq | output | 7 | Bit L-1 is set when processor level L is requested |
| ackValid | input | 1 | Acknowledge strobe |
| ackLevel | input | 3 | Level being acknowledged |
| vecWrEn | input | 1 | Vector table write enable |
| vecWrAddr | input | 5 | Vector table entry index |
| vecWrData | input | 16 | Vector to store |
| rspValid | output | 1 | Acknowledge response valid |
| rspVector | output | 16 | Vector of the winning line, or 0 |
| rspAdapter | output | 2 | Encoded adapter number (1 or 3), or 0 on a miss |

## Verification
A lost or stuck pending bit shows up on `levelReq` in the cycle after the edge that corrupted it. A clear applied to the wrong line shows up the same way, and it also shows up one acknowledge later as a wrong vector or an unexpected miss. A broken search order shows up in the response cycle right after the acknowledge, as the wrong adapter code or the vector of the wrong line. The bench follows every cycle with its own model of the pending set and the vector table, so each of these faults is caught at its first visible cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Strobes from the search control into the datapath
  typedef struct packed {
    logic take;   // an acknowledge is being answered this cycle
    logic hit;    // a line won and must be cleared
    logic load;   // vector table write this cycle
  } arbStrobe_t;
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int WIDTH = 32,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] candMask,
  output logic [IDX_W-1:0] pickIdx,
  output logic             pickAny
);
  always_comb begin
    pickIdx = '0;
    pickAny = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (candMask[i]) begin
        pickIdx = IDX_W'(i);
        pickAny = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES    = 32,
  parameter int NUM_ADAPTERS = 2,
  parameter int LVL_W        = 3,
  parameter logic [NUM_ADAPTERS*NUM_LINES-1:0] HI_MASKS = '0,
  parameter logic [NUM_ADAPTERS*NUM_LINES-1:0] LO_MASKS = '0,
  localparam int NUM_LVLS = (1 << LVL_W) - 1,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int AD_W     = (NUM_ADAPTERS > 1) ? $clog2(NUM_ADAPTERS) : 1,
  localparam int CODE_W   = AD_W + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_LINES-1:0]          pending,
  input  logic [NUM_ADAPTERS*LVL_W-1:0] hiLevels,
  input  logic [NUM_ADAPTERS*LVL_W-1:0] loLevels,
  input  logic                          ackValid,
  input  logic [LVL_W-1:0]              ackLevel,
  input  logic                          vecWrEn,
  output logic [NUM_LVLS-1:0]           levelReq,
  output arbStrobe_t                    strobe,
  output logic [IDX_W-1:0]              winIdx,
  output logic [CODE_W-1:0]             winCode
);
  logic [NUM_LINES-1:0] hiGrp [NUM_ADAPTERS];
  logic [NUM_LINES-1:0] loGrp [NUM_ADAPTERS];
  logic [LVL_W-1:0]     hiLvl [NUM_ADAPTERS];
  logic [LVL_W-1:0]     loLvl [NUM_ADAPTERS];
  logic                 hiAny [NUM_ADAPTERS];
  logic                 loAny [NUM_ADAPTERS];

  for (genvar a = 0; a < NUM_ADAPTERS; a++) begin : g_adapter
    assign hiGrp[a] = pending & HI_MASKS[a*NUM_LINES +: NUM_LINES];
    assign loGrp[a] = pending & LO_MASKS[a*NUM_LINES +: NUM_LINES];
    assign hiLvl[a] = hiLevels[a*LVL_W +: LVL_W];
    assign loLvl[a] = loLevels[a*LVL_W +: LVL_W];
    assign hiAny[a] = |hiGrp[a];
    assign loAny[a] = |loGrp[a];
  end

  // Level bitmap: one-hot contribution per active group
  always_comb begin
    levelReq = '0;
    for (int a = 0; a < NUM_ADAPTERS; a++) begin
      if (hiAny[a] && (hiLvl[a] != '0)) levelReq[hiLvl[a] - 1'b1] = 1'b1;
      if (loAny[a] && (loLvl[a] != '0)) levelReq[loLvl[a] - 1'b1] = 1'b1;
    end
  end

  // Group search: adapter order, high group before low group
  logic                 found;
  logic [NUM_LINES-1:0] selMask;
  logic [AD_W-1:0]      selAdapter;

  always_comb begin
    found      = 1'b0;
    selMask    = '0;
    selAdapter = '0;
    for (int a = 0; a < NUM_ADAPTERS; a++) begin
      if (!found && hiAny[a] && (hiLvl[a] != '0) && (hiLvl[a] == ackLevel)) begin
        found      = 1'b1;
        selMask    = hiGrp[a];
        selAdapter = AD_W'(a);
      end
      if (!found && loAny[a] && (loLvl[a] != '0) && (loLvl[a] == ackLevel)) begin
        found      = 1'b1;
        selMask    = loGrp[a];
        selAdapter = AD_W'(a);
      end
    end
  end

  logic pickAny;

  irq_lowest_pick #(.WIDTH(NUM_LINES)) u_pick (
    .candMask (selMask),
    .pickIdx  (winIdx),
    .pickAny  (pickAny)
  );

  assign strobe.take = ackValid;
  assign strobe.hit  = ackValid && found && pickAny;
  assign strobe.load = vecWrEn;
  assign winCode     = strobe.hit ? {selAdapter, 1'b1} : '0;

  AST_IDLE_NO_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (pending == '0) |-> (levelReq == '0)); // R4
  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hit |-> pending[winIdx]); // R6
  AST_CODE_ODD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hit |-> winCode[0]); // R9
endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int VEC_W     = 16,
  parameter int CODE_W    = 2,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqSet,
  input  arbStrobe_t           strobe,
  input  logic [IDX_W-1:0]     winIdx,
  input  logic [CODE_W-1:0]    winCode,
  input  logic [IDX_W-1:0]     vecWrAddr,
  input  logic [VEC_W-1:0]     vecWrData,
  output logic [NUM_LINES-1:0] pending,
  output logic                 rspValid,
  output logic [VEC_W-1:0]     rspVector,
  output logic [CODE_W-1:0]    rspAdapter
);
  logic [VEC_W-1:0]     vecTable [NUM_LINES];
  logic [NUM_LINES-1:0] clrMask;

  assign clrMask = strobe.hit ? (NUM_LINES'(1) << winIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= (pending & ~clrMask) | reqSet;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rstN) vecTable[i] <= '0;
      else if (strobe.load && (vecWrAddr == IDX_W'(i))) vecTable[i] <= vecWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspVector  <= '0;
      rspAdapter <= '0;
    end else begin
      rspValid <= strobe.take;
      if (strobe.take) begin
        rspVector  <= strobe.hit ? vecTable[winIdx] : '0;
        rspAdapter <= winCode;
      end
    end
  end

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clrMask)); // R6
  AST_WIN_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hit && !reqSet[winIdx]) |=> !pending[$past(winIdx)]); // R6
  AST_RSP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> rspValid); // R7
  AST_RSP_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(strobe.take)) |-> 1'b0); // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspAdapter == '0)) |-> (rspVector == '0)); // R8
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES    = 32,
  parameter int NUM_ADAPTERS = 2,
  parameter int LVL_W        = 3,
  parameter int VEC_W        = 16,
  parameter logic [NUM_ADAPTERS*NUM_LINES-1:0] HI_MASKS = {32'h0000_FF00, 32'h0000_000F},
  parameter logic [NUM_ADAPTERS*NUM_LINES-1:0] LO_MASKS = {32'hFFFF_0000, 32'h0000_00F0},
  localparam int NUM_LVLS = (1 << LVL_W) - 1,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int AD_W     = (NUM_ADAPTERS > 1) ? $clog2(NUM_ADAPTERS) : 1,
  localparam int CODE_W   = AD_W + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_LINES-1:0]          reqSet,
  input  logic [NUM_ADAPTERS*LVL_W-1:0] hiLevels,
  input  logic [NUM_ADAPTERS*LVL_W-1:0] loLevels,
  output logic [NUM_LVLS-1:0]           levelReq,
  input  logic                          ackValid,
  input  logic [LVL_W-1:0]              ackLevel,
  input  logic                          vecWrEn,
  input  logic [IDX_W-1:0]              vecWrAddr,
  input  logic [VEC_W-1:0]              vecWrData,
  output logic                          rspValid,
  output logic [VEC_W-1:0]              rspVector,
  output logic [CODE_W-1:0]             rspAdapter
);
  logic [NUM_LINES-1:0] pending;
  arbStrobe_t           strobe;
  logic [IDX_W-1:0]     winIdx;
  logic [CODE_W-1:0]    winCode;

  irq_arb_ctrl #(
    .NUM_LINES(NUM_LINES), .NUM_ADAPTERS(NUM_ADAPTERS), .LVL_W(LVL_W),
    .HI_MASKS(HI_MASKS), .LO_MASKS(LO_MASKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pending(pending),
    .hiLevels(hiLevels), .loLevels(loLevels),
    .ackValid(ackValid), .ackLevel(ackLevel), .vecWrEn(vecWrEn),
    .levelReq(levelReq), .strobe(strobe), .winIdx(winIdx), .winCode(winCode)
  );

  irq_arb_datapath #(
    .NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .strobe(strobe),
    .winIdx(winIdx), .winCode(winCode),
    .vecWrAddr(vecWrAddr), .vecWrData(vecWrData),
    .pending(pending), .rspValid(rspValid),
    .rspVector(rspVector), .rspAdapter(rspAdapter)
  );
endmodule

// File: tb/irq_vector_arbiter_bench.sv
module irq_vector_arbiter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] reqSet = '0;
  logic [5:0]  hiLevels = '0;
  logic [5:0]  loLevels = '0;
  logic [6:0]  levelReq;
  logic        ackValid = 1'b0;
  logic [2:0]  ackLevel = '0;
  logic        vecWrEn = 1'b0;
  logic [4:0]  vecWrAddr = '0;
  logic [15:0] vecWrData = '0;
  logic        rspValid;
  logic [15:0] rspVector;
  logic [1:0]  rspAdapter;

  always #10 clk = ~clk;

  irq_vector_arbiter u_irq_vector_arbiter (.*);

  localparam logic [31:0] HI_M [2] = '{32'h0000_000F, 32'h0000_FF00};
  localparam logic [31:0] LO_M [2] = '{32'h0000_00F0, 32'hFFFF_0000};

  int          nChecks = 0;
  int          nFails  = 0;
  logic [31:0] mPend   = '0;
  logic [15:0] mTbl [32];
  logic        eRspValid = 1'b0;
  logic [15:0] eVec  = '0;
  logic [1:0]  eCode = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] hiL(int a); return hiLevels[a*3 +: 3]; endfunction
  function automatic logic [2:0] loL(int a); return loLevels[a*3 +: 3]; endfunction

  function automatic logic [6:0] expLevels(logic [31:0] p);
    logic [6:0] r = '0;
    for (int a = 0; a < 2; a++) begin
      if (|(p & HI_M[a]) && hiL(a) != 0) r[hiL(a) - 1] = 1'b1;
      if (|(p & LO_M[a]) && loL(a) != 0) r[loL(a) - 1] = 1'b1;
    end
    return r;
  endfunction

  // Returns winning line or -1; adapter index via ref
  function automatic int predict(logic [31:0] p, logic [2:0] lvl, ref int adp);
    logic [31:0] m = '0;
    adp = -1;
    for (int a = 0; a < 2 && adp < 0; a++) begin
      if (hiL(a) != 0 && hiL(a) == lvl && |(p & HI_M[a])) begin m = p & HI_M[a]; adp = a; end
      else if (loL(a) != 0 && loL(a) == lvl && |(p & LO_M[a])) begin m = p & LO_M[a]; adp = a; end
    end
    for (int i = 0; i < 32; i++) if (m[i]) return i;
    return -1;
  endfunction

  // One cycle: check outputs, drive inputs, advance the model
  task automatic step(input logic [31:0] rs, input bit av, input logic [2:0] al,
                      input bit we, input logic [4:0] wa, input logic [15:0] wd);
    int adp;
    int win;
    #1;
    chk(levelReq == expLevels(mPend), "R1 R2 R3 R4 levelReq", 32'(levelReq), 32'(expLevels(mPend)));
    chk(rspValid == eRspValid, "R7 rspValid", 32'(rspValid), 32'(eRspValid));
    if (eRspValid) begin
      chk(rspVector == eVec, "R5 R6 R10 rspVector", 32'(rspVector), 32'(eVec));
      chk(rspAdapter == eCode, "R8 R9 rspAdapter", 32'(rspAdapter), 32'(eCode));
    end
    reqSet = rs; ackValid = av; ackLevel = al;
    vecWrEn = we; vecWrAddr = wa; vecWrData = wd;
    eRspValid = av;
    if (av) begin
      win = predict(mPend, al, adp);
      if (win >= 0) begin
        eVec = mTbl[win];
        eCode = 2'(2 * adp + 1);
        mPend[win] = 1'b0;
      end else begin
        eVec = '0;
        eCode = '0;
      end
    end
    mPend = mPend | rs;
    if (we) mTbl[wa] = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(); step('0, 1'b0, 3'd0, 1'b0, 5'd0, 16'd0); endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 32; i++) mTbl[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(levelReq == '0, "R11 levelReq in reset", 32'(levelReq), 0);
    chk(rspValid == 1'b0, "R11 rspValid in reset", 32'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table cleared by reset: hit with zero vector (R11, R9)
    hiLevels = {3'd0, 3'd4};
    step(32'h1, 1'b0, 3'd0, 1'b0, 5'd0, 16'd0);
    step('0, 1'b1, 3'd4, 1'b0, 5'd0, 16'd0);
    idle();
    // Load vectors for every line (R10)
    for (int i = 0; i < 32; i++) step('0, 1'b0, 3'd0, 1'b1, 5'(i), 16'h0100 + 16'(i * 4));
    // Order: adapter 0 before adapter 1, both high groups on level 5 (R5, R9)
    hiLevels = {3'd5, 3'd5}; loLevels = {3'd2, 3'd3};
    step(32'h0000_0201, 1'b0, 3'd0, 1'b0, 5'd0, 16'd0);
    step('0, 1'b1, 3'd5, 1'b0, 5'd0, 16'd0);
    step('0, 1'b1, 3'd5, 1'b0, 5'd0, 16'd0);
    // High before low in one adapter on shared level (R5)
    loLevels = {3'd2, 3'd5};
    step(32'h0000_0024, 1'b0, 3'd0, 1'b0, 5'd0, 16'd0);
    step('0, 1'b1, 3'd5, 1'b0, 5'd0, 16'd0);
    step('0, 1'b1, 3'd5, 1'b0, 5'd0, 16'd0);
    // Lowest line wins (R6), miss returns zero (R8)
    step(32'h0006_0000, 1'b0, 3'd0, 1'b0, 5'd0, 16'd0);
    step('0, 1'b1, 3'd2, 1'b0, 5'd0, 16'd0);
    step('0, 1'b1, 3'd7, 1'b0, 5'd0, 16'd0);
    step('0, 1'b1, 3'd2, 1'b0, 5'd0, 16'd0);
    // Level field zero contributes nothing (R4)
    hiLevels = {3'd0, 3'd0};
    step(32'h0000_0100, 1'b0, 3'd0, 1'b0, 5'd0, 16'd0);
    step('0, 1'b1, 3'd0, 1'b0, 5'd0, 16'd0);
    // Set and clear same line same edge keeps it pending (R1); write during ack reads old (R10)
    hiLevels = {3'd6, 3'd1};
    step(32'h0000_0008, 1'b0, 3'd0, 1'b0, 5'd0, 16'd0);
    step(32'h0000_0008, 1'b1, 3'd1, 1'b1, 5'd3, 16'hBEEF);
    step('0, 1'b1, 3'd1, 1'b0, 5'd0, 16'd0);
    idle();

    // Constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      if (c % 40 == 0) begin
        hiLevels = 6'($urandom);
        loLevels = 6'($urandom);
      end
      step($urandom & $urandom & $urandom & $urandom,
           ($urandom % 10) < 4, 3'($urandom),
           ($urandom % 10) < 2, 5'($urandom), 16'($urandom));
    end
    idle(); idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule